// File: doc/BRIEF.md
# Configurable PCM Serial Transmitter

This block turns stereo PCM sample pairs into a three-wire serial stream for an audio DAC: a bit clock, a word clock that marks the left and right slots, and a serial data line. The bit clock is made inside the block from a single-cycle enable tick on the system clock. Every tick toggles the bit clock. The block counts bit clocks to produce the word clock, so no second clock domain is needed.

A format selection sets the sample precision (16, 18, 20 or 24 bits), which end of the sample is sent first, and which side of the slot holds the padding. A routing selection decides which input channel feeds each slot. Sample pairs arrive on a valid/ready handshake, one pair per word-clock frame. If no pair is offered when a frame begins, the frame carries silence.

Top module: `pcm_serial_tx`

## Requirements
- R1: With precision code 0 (16 bits), one word-clock period spans exactly 32 bit clocks, 16 in each slot.
- R2: With precision codes 1, 2 or 3 (18, 20, 24 bits), one word-clock period spans exactly 64 bit clocks, 32 in each slot.
- R3: The 2-bit precision code maps 0, 1, 2, 3 to 16, 18, 20, 24 bits. A sample of P bits sits in bits [P-1:0] of the 24-bit input word. Input bits above P never reach the line.
- R4: With lsb_first at 0, each sample is sent from bit P-1 down to bit 0. With lsb_first at 1, it is sent from bit 0 up to bit P-1.
- R5: With pad_lead at 0, the sample fills the start of the slot and the remaining slot bits follow it. With pad_lead at 1, the padding comes first and the sample ends the slot. Padding bits are always 0.
- R6: The route code selects the slots: 0 sends left then right, 1 sends right then left, 2 sends left in both slots, 3 sends right in both slots. After reset the code in force is 0.
- R7: The word clock is 0 while the left slot is sent and 1 while the right slot is sent. It changes on the bit-clock falling edge that puts the slot's first bit on the data line.
- R8: The bit clock toggles once per bit_tick and is 0 after reset. Data and word clock change only together with a falling bit-clock edge, so they hold steady across every rising edge.
- R9: in_ready is high for one system-clock cycle, in the cycle where the bit clock falls to start a frame. If in_valid is high in that cycle, the pair is taken. If it is low, the frame sends zeros in both slots. Precision, order, padding and route are sampled in that same cycle and hold for the whole frame.
- R10: During and straight after reset, bclk is 0, wclk is 1, sdo is 0 and in_ready is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_tick | input | 1 | Enable pulse; each one toggles the bit clock |
| prec_sel | input | 2 | Precision code (0:16, 1:18, 2:20, 3:24 bits) |
| lsb_first | input | 1 | 1 sends the least significant bit first |
| pad_lead | input | 1 | 1 places padding before the sample in its slot |
| route_sel | input | 2 | Slot routing code |
| in_left | input | 24 | Left sample, right-aligned |
| in_right | input | 24 | Right sample, right-aligned |
| in_valid | input | 1 | Sample pair offered |
| in_ready | output | 1 | Pair accepted at this frame start |
| sdo | output | 1 | Serial data |
| bclk | output | 1 | Bit clock |
| wclk | output | 1 | Word clock (0 left, 1 right) |

## Verification
The assertions assume that bit_tick never stays high for two cycles in a row, so each bit-clock half period lasts at least two system clocks. They also assume that the format and sample inputs matter only in the frame-start cycle. The bench drives bit_tick on every second clock. It changes the format, route and sample inputs only in the cycle after in_ready, so every frame is checked against the settings captured for it. Frames with in_valid low are mixed in to check the silence path.

// File: rtl/pcm_tx_pkg.sv
// Shared types for the PCM serial transmitter.
// Assumes: precisions are limited to the four listed codes.
package pcm_tx_pkg;

    typedef enum logic [1:0] {
        PREC_16 = 2'd0,
        PREC_18 = 2'd1,
        PREC_20 = 2'd2,
        PREC_24 = 2'd3
    } prec_e;

    typedef enum logic [1:0] {
        ROUTE_NORMAL     = 2'd0,
        ROUTE_SWAP       = 2'd1,
        ROUTE_LEFT_BOTH  = 2'd2,
        ROUTE_RIGHT_BOTH = 2'd3
    } route_e;

    typedef struct packed {
        prec_e prec;
        logic  lsb_first;
        logic  pad_lead;
    } fmt_t;

    // Number of meaningful sample bits for a precision code.
    function automatic int prec_bits(prec_e p);
        case (p)
            PREC_16: return 16;
            PREC_18: return 18;
            PREC_20: return 20;
            default: return 24;
        endcase
    endfunction

endpackage

// File: rtl/pcm_tx_clkgen.sv
// Bit-clock generator and frame position counter.
// Toggles bclk on every bit_tick and advances the bit position on each
// falling bclk edge, wrapping at the end of a short or a long frame.
// Assumes: bit_tick is never high on two consecutive cycles.
module pcm_tx_clkgen #(
    parameter int SHORT_SLOT = 16,
    parameter int LONG_SLOT  = 32,
    localparam int POS_W     = $clog2(2 * LONG_SLOT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_tick,
    input  logic             long_frame,
    output logic             bclk,
    output logic [POS_W-1:0] pos,
    output logic             frame_start
);

    localparam logic [POS_W-1:0] LAST_SHORT = POS_W'(2 * SHORT_SLOT - 1);
    localparam logic [POS_W-1:0] LAST_LONG  = POS_W'(2 * LONG_SLOT - 1);
    localparam logic [POS_W-1:0] MID_LONG   = POS_W'(2 * SHORT_SLOT);

    logic             bclk_q;
    logic [POS_W-1:0] pos_q;
    logic             fall;
    logic [POS_W-1:0] last_pos;

    // Decode the falling edge and the frame boundary.
    always_comb begin
        fall        = bit_tick & bclk_q;
        last_pos    = long_frame ? LAST_LONG : LAST_SHORT;
        frame_start = fall & (pos_q == last_pos);
    end

    // Bit clock toggle and position advance on the falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bclk_q <= 1'b0;
            pos_q  <= LAST_SHORT;
        end else if (bit_tick) begin
            bclk_q <= ~bclk_q;
            if (bclk_q) begin
                pos_q <= frame_start ? '0 : pos_q + POS_W'(1);
            end
        end
    end

    assign bclk = bclk_q;
    assign pos  = pos_q;

    AST_BCLK_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |=> (bclk != $past(bclk)));  // R8

    AST_SHORT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_tick && bclk && !long_frame && pos == LAST_SHORT) |=> (pos == '0));  // R1

    AST_LONG_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_tick && bclk && long_frame && pos == LAST_SHORT) |=> (pos == MID_LONG));  // R2

endmodule

// File: rtl/pcm_tx_loader.sv
// Frame-start capture of the sample pair and the format settings.
// Applies slot routing at capture; with no valid pair, captures zeros.
// Assumes: frame_start is a single-cycle pulse.
module pcm_tx_loader
    import pcm_tx_pkg::*;
#(
    parameter int SAMPLE_W = 24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frame_start,
    input  logic                in_valid,
    input  logic [SAMPLE_W-1:0] in_left,
    input  logic [SAMPLE_W-1:0] in_right,
    input  fmt_t                fmt_in,
    input  route_e              route_in,
    output fmt_t                fmt_q,
    output logic [SAMPLE_W-1:0] slot_a,
    output logic [SAMPLE_W-1:0] slot_b,
    output logic                in_ready
);

    logic [SAMPLE_W-1:0] route_a;
    logic [SAMPLE_W-1:0] route_b;

    // Select which input channel feeds each slot.
    always_comb begin
        case (route_in)
            ROUTE_SWAP:       begin route_a = in_right; route_b = in_left;  end
            ROUTE_LEFT_BOTH:  begin route_a = in_left;  route_b = in_left;  end
            ROUTE_RIGHT_BOTH: begin route_a = in_right; route_b = in_right; end
            default:          begin route_a = in_left;  route_b = in_right; end
        endcase
    end

    // Capture samples and format once per frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fmt_q  <= '{prec: PREC_16, lsb_first: 1'b0, pad_lead: 1'b0};
            slot_a <= '0;
            slot_b <= '0;
        end else if (frame_start) begin
            fmt_q  <= fmt_in;
            slot_a <= in_valid ? route_a : '0;
            slot_b <= in_valid ? route_b : '0;
        end
    end

    assign in_ready = frame_start;

    AST_SILENT_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && !in_valid) |=> (slot_a == '0 && slot_b == '0));  // R9

    AST_LEFT_BOTH_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && in_valid && route_in == ROUTE_LEFT_BOTH) |=> (slot_a == slot_b));  // R6

endmodule

// File: rtl/pcm_tx_serializer.sv
// Combinational bit picker: maps the frame position and captured format
// to the current data bit and the slot (word clock) level.
// Assumes: LONG_SLOT is twice SHORT_SLOT and SAMPLE_W holds 24 bits.
module pcm_tx_serializer
    import pcm_tx_pkg::*;
#(
    parameter int SAMPLE_W   = 24,
    parameter int SHORT_SLOT = 16,
    parameter int LONG_SLOT  = 32,
    localparam int POS_W     = $clog2(2 * LONG_SLOT),
    localparam int IDX_W     = $clog2(SAMPLE_W)
) (
    input  logic [POS_W-1:0]    pos,
    input  fmt_t                fmt,
    input  logic [SAMPLE_W-1:0] slot_a,
    input  logic [SAMPLE_W-1:0] slot_b,
    output logic                long_frame,
    output logic                sdo,
    output logic                wclk
);

    logic                slot_sel;
    logic                in_data;
    logic [IDX_W-1:0]    sel_idx;
    logic [SAMPLE_W-1:0] sample;
    int                  offs;
    int                  slot_len;
    int                  pbits;
    int                  k;
    int                  kk;

    // Locate the bit inside the slot and pick it from the sample.
    always_comb begin
        long_frame = (fmt.prec != PREC_16);
        slot_sel   = long_frame ? pos[POS_W-1] : pos[POS_W-2];
        offs       = long_frame ? int'(pos[POS_W-2:0]) : int'(pos[POS_W-3:0]);
        slot_len   = long_frame ? LONG_SLOT : SHORT_SLOT;
        pbits      = prec_bits(fmt.prec);
        k          = fmt.pad_lead ? offs - (slot_len - pbits) : offs;
        in_data    = (k >= 0) && (k < pbits);
        kk         = fmt.lsb_first ? k : pbits - 1 - k;
        sel_idx    = in_data ? IDX_W'(kk) : '0;
        sample     = slot_sel ? slot_b : slot_a;
        sdo        = in_data & sample[sel_idx];
        wclk       = slot_sel;
    end

endmodule

// File: rtl/pcm_serial_tx.sv
// Top of the PCM serial transmitter: bit-clock generator, frame loader
// and bit picker. Outputs change only with a falling bit-clock edge.
// Assumes: bit_tick pulses are separated by at least one idle cycle.
module pcm_serial_tx
    import pcm_tx_pkg::*;
#(
    parameter int SAMPLE_W   = 24,
    parameter int SHORT_SLOT = 16,
    parameter int LONG_SLOT  = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bit_tick,
    input  logic [1:0]          prec_sel,
    input  logic                lsb_first,
    input  logic                pad_lead,
    input  logic [1:0]          route_sel,
    input  logic [SAMPLE_W-1:0] in_left,
    input  logic [SAMPLE_W-1:0] in_right,
    input  logic                in_valid,
    output logic                in_ready,
    output logic                sdo,
    output logic                bclk,
    output logic                wclk
);

    localparam int POS_W = $clog2(2 * LONG_SLOT);

    logic [POS_W-1:0]    pos;
    logic                frame_start;
    logic                long_frame;
    fmt_t                fmt_in;
    fmt_t                fmt_q;
    logic [SAMPLE_W-1:0] slot_a;
    logic [SAMPLE_W-1:0] slot_b;

    // Pack the format pins into the shared structure.
    always_comb begin
        fmt_in.prec      = prec_e'(prec_sel);
        fmt_in.lsb_first = lsb_first;
        fmt_in.pad_lead  = pad_lead;
    end

    pcm_tx_clkgen #(
        .SHORT_SLOT (SHORT_SLOT),
        .LONG_SLOT  (LONG_SLOT)
    ) u_clkgen (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_tick    (bit_tick),
        .long_frame  (long_frame),
        .bclk        (bclk),
        .pos         (pos),
        .frame_start (frame_start)
    );

    pcm_tx_loader #(
        .SAMPLE_W (SAMPLE_W)
    ) u_loader (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .in_valid    (in_valid),
        .in_left     (in_left),
        .in_right    (in_right),
        .fmt_in      (fmt_in),
        .route_in    (route_e'(route_sel)),
        .fmt_q       (fmt_q),
        .slot_a      (slot_a),
        .slot_b      (slot_b),
        .in_ready    (in_ready)
    );

    pcm_tx_serializer #(
        .SAMPLE_W   (SAMPLE_W),
        .SHORT_SLOT (SHORT_SLOT),
        .LONG_SLOT  (LONG_SLOT)
    ) u_serializer (
        .pos        (pos),
        .fmt        (fmt_q),
        .slot_a     (slot_a),
        .slot_b     (slot_b),
        .long_frame (long_frame),
        .sdo        (sdo),
        .wclk       (wclk)
    );

    AST_LINES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(bit_tick && bclk) |=> ($stable(sdo) && $stable(wclk)));  // R8

    AST_TAIL_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt_q.prec == PREC_18 && !fmt_q.pad_lead && pos[4:0] >= 5'd18) |-> !sdo);  // R5

    AST_HEAD_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt_q.prec == PREC_18 && fmt_q.pad_lead && pos[4:0] < 5'd14) |-> !sdo);  // R5

endmodule

// File: tb/pcm_serial_tx_test.sv
// Scoreboard bench: the driver pushes the expected line bits of each
// accepted frame; the monitor pops one per rising bit-clock edge.
module pcm_serial_tx_test;

    typedef struct {
        logic [1:0]  prec;
        logic        lsb;
        logic        lead;
        logic [1:0]  route;
        logic        valid;
        logic [23:0] l;
        logic [23:0] r;
        string       tag;
    } item_t;

    typedef struct {
        logic  sd;
        logic  ws;
        bit    first;
        int    flen;
        string tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_tick = 1'b0;
    logic [1:0]  prec_sel = 2'd0;
    logic        lsb_first = 1'b0;
    logic        pad_lead = 1'b0;
    logic [1:0]  route_sel = 2'd0;
    logic [23:0] in_left = '0;
    logic [23:0] in_right = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic        sdo;
    logic        bclk;
    logic        wclk;

    int    checks = 0;
    int    errors = 0;
    item_t items[$];
    exp_t  q[$];
    int    idx = 0;
    bit    load_next = 0;
    bit    stim_done = 0;
    bit    running = 0;
    bit    prev_ready = 0;

    pcm_serial_tx uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_tick  (bit_tick),
        .prec_sel  (prec_sel),
        .lsb_first (lsb_first),
        .pad_lead  (pad_lead),
        .route_sel (route_sel),
        .in_left   (in_left),
        .in_right  (in_right),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .sdo       (sdo),
        .bclk      (bclk),
        .wclk      (wclk)
    );

    always #4 clk = ~clk;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic add(input logic [1:0] p, input logic lsb, input logic lead,
                       input logic [1:0] rt, input logic v, input logic [23:0] l,
                       input logic [23:0] r, input string tag);
        item_t it;
        it.prec = p; it.lsb = lsb; it.lead = lead; it.route = rt;
        it.valid = v; it.l = l; it.r = r; it.tag = tag;
        items.push_back(it);
    endtask

    task automatic apply(input item_t it);
        prec_sel  = it.prec;
        lsb_first = it.lsb;
        pad_lead  = it.lead;
        route_sel = it.route;
        in_valid  = it.valid;
        in_left   = it.l;
        in_right  = it.r;
    endtask

    // Expected line bits of one frame, from the requirements.
    task automatic push_frame(input item_t it);
        int plen;
        int slen;
        plen = (it.prec == 2'd0) ? 16 : (it.prec == 2'd1) ? 18 : (it.prec == 2'd2) ? 20 : 24;
        slen = (it.prec == 2'd0) ? 16 : 32;
        for (int s = 0; s < 2; s++) begin
            logic [23:0] smp;
            case (it.route)
                2'd1:    smp = (s == 0) ? it.r : it.l;
                2'd2:    smp = it.l;
                2'd3:    smp = it.r;
                default: smp = (s == 0) ? it.l : it.r;
            endcase
            if (!it.valid) smp = '0;
            for (int p = 0; p < slen; p++) begin
                exp_t e;
                logic [23:0] sh;
                int k;
                k = it.lead ? p - (slen - plen) : p;
                e.sd = 1'b0;
                if (k >= 0 && k < plen) begin
                    sh = it.lsb ? (smp >> k) : (smp >> (plen - 1 - k));
                    e.sd = sh[0];
                end
                e.ws = (s == 1);
                e.first = (s == 0 && p == 0);
                e.flen = 2 * slen;
                e.tag = it.tag;
                q.push_back(e);
            end
        end
    endtask

    // Driver: tick generation, frame acceptance and expected-bit pushes.
    always @(negedge clk) begin
        if (running) begin
            if (load_next) begin
                load_next = 0;
                idx++;
                if (idx < items.size()) apply(items[idx]);
                else begin in_valid = 1'b0; stim_done = 1; end
            end
            bit_tick = ~bit_tick;
            #1;
            if (in_ready) begin
                check(bclk === 1'b1, "R9", "in_ready outside a falling edge", int'(bclk), 1);
                check(!prev_ready, "R9", "in_ready longer than one cycle", 2, 1);
                if (!stim_done) push_frame(items[idx]);
                load_next = 1;
            end
            prev_ready = in_ready;
        end
    end

    // Monitor: compare line state at each rising bit-clock edge.
    logic p_bclk = 1'b0;
    logic p_sdo = 1'b0;
    logic p_wclk = 1'b1;
    int   rises = 0;
    int   prev_flen = 0;
    bit   have_prev = 0;
    always @(negedge clk) begin
        if (running) begin
            if (sdo !== p_sdo || wclk !== p_wclk)
                check(bclk === 1'b0 && p_bclk === 1'b1, "R8", "lines moved without a falling bclk",
                      int'(bclk), 0);
            if (bclk === 1'b1 && p_bclk === 1'b0 && q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                if (e.first) begin
                    if (have_prev)
                        check(rises == prev_flen, (prev_flen == 32) ? "R1" : "R2",
                              "bit clocks per frame", rises, prev_flen);
                    prev_flen = e.flen;
                    rises = 1;
                    have_prev = 1;
                end else begin
                    rises++;
                end
                check(wclk === e.ws, "R7", "word clock level", int'(wclk), int'(e.ws));
                check(sdo === e.sd, e.tag, "data bit", int'(sdo), int'(e.sd));
            end
            p_bclk = bclk;
            p_sdo  = sdo;
            p_wclk = wclk;
        end
    end

    initial begin
        bit done;
        // R1 R4 R3 R2 R5 R6 R9 stimulus list
        add(2'd0, 0, 0, 2'd0, 1, 24'h00A5C3, 24'h005A3C, "R1");
        add(2'd0, 1, 0, 2'd0, 1, 24'h001234, 24'h00F00F, "R4");
        add(2'd0, 0, 0, 2'd0, 1, 24'hFF8001, 24'hC37E11, "R3");
        add(2'd3, 0, 0, 2'd0, 1, 24'hA1B2C3, 24'h5E6F70, "R2");
        add(2'd3, 1, 0, 2'd0, 1, 24'h800001, 24'h0F0F0F, "R4");
        add(2'd1, 0, 0, 2'd0, 1, 24'hFFFFFF, 24'h3FFFFF, "R5");
        add(2'd1, 0, 1, 2'd0, 1, 24'hFFFFFF, 24'h2AAAA, "R5");
        add(2'd2, 1, 1, 2'd0, 1, 24'hFFFFFF, 24'h0C3A5, "R5");
        add(2'd2, 0, 0, 2'd1, 1, 24'h0ABCDE, 24'h012345, "R6");
        add(2'd3, 0, 0, 2'd2, 1, 24'h13579B, 24'hFDB975, "R6");
        add(2'd0, 0, 0, 2'd3, 1, 24'h00BEEF, 24'h00CAFE, "R6");
        add(2'd3, 0, 0, 2'd0, 0, 24'hFFFFFF, 24'hFFFFFF, "R9");
        add(2'd0, 1, 1, 2'd0, 1, 24'h00F731, 24'h00137F, "R9");
        add(2'd2, 0, 0, 2'd0, 1, 24'hF5A5A5, 24'hE00001, "R3");
        apply(items[0]);
        repeat (4) @(negedge clk);
        // R10 reset state
        check(bclk === 1'b0, "R10", "bclk in reset", int'(bclk), 0);
        check(wclk === 1'b1, "R10", "wclk in reset", int'(wclk), 1);
        check(sdo === 1'b0, "R10", "sdo in reset", int'(sdo), 0);
        check(in_ready === 1'b0, "R10", "in_ready in reset", int'(in_ready), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(bclk === 1'b0 && wclk === 1'b1, "R10", "state after reset", int'(wclk), 1);
        running = 1;
        done = 0;
        for (int c = 0; c < 100000 && !done; c++) begin
            @(posedge clk);
            done = stim_done && (q.size() == 0);
        end
        if (!done) check(0, "R9", "watchdog expired, frames pending", q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule